// File: doc/BRIEF.md
# Banked Static Memory Array with Row Decode and Column Select

This block is a synchronous single-port memory holding `2**(ROW_W+COL_W)` words of `DATA_W` bits. The word is not stored as one wide array. Each data bit has its own one-bit-wide bank of `2**ROW_W` rows by `2**COL_W` columns. The upper address bits form a row field. One shared decoder turns that field into a one-hot row select, and the same select is applied to every bank. Each bank returns the whole selected row. A column multiplexer in each bank then takes one bit of that row, using the lower address bits. Together, the picked bits form the read word.

Chip select gates every access. A write stores one bit into each bank at the addressed row and column. A read is captured into an output register one clock after the address is presented. Output enable gates the data output and has no latency. When output enable is low, the output is either high impedance or a fixed idle pattern, chosen by a parameter.

Top module: `sram_bank`

## Requirements
- R1: The address splits as row = `addr_i[ROW_W+COL_W-1:COL_W]` and column = `addr_i[COL_W-1:0]`. Every address, including 0 and the all-ones address, holds its own word. Two addresses that share a row or share a column do not disturb each other.
- R2: With `cs_i`=1 and `we_i`=1 at a rising edge, `wdata_i` is stored at `addr_i`. No other address changes.
- R3: With `cs_i`=1 and `we_i`=0 at a rising edge, the word at `addr_i` appears on the read register after that edge. This includes a word written in the cycle just before.
- R4: With `cs_i`=0, a write request (`we_i`=1) stores nothing.
- R5: With `cs_i`=0, the read register keeps its value.
- R6: During a write cycle, the read register keeps its value. A write never updates read data.
- R7: `rdata_o` follows the read register while `oe_i`=1. It equals the idle value while `oe_i`=0, with no clock delay. The idle value is all ones by default, or high impedance when `IDLE_Z`=1.
- R8: While `rst_ni`=0, the read register is all zeros. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the read register |
| cs_i | input | 1 | Chip select; gates all access |
| we_i | input | 1 | 1 = write, 0 = read when selected |
| oe_i | input | 1 | Output enable for rdata_o |
| addr_i | input | ROW_W+COL_W | Word address: row field high, column field low |
| wdata_i | input | DATA_W | Write data, bit b goes to bank b |
| rdata_o | output | DATA_W | Registered read data, gated by oe_i |

## Verification
Some properties hold on every cycle, and the assertions check these. The read register holds through deselected and write cycles. The output tracks the register or the idle value according to output enable. The register is cleared during reset. A read that follows a write to the same address returns the written word. Whole-array behaviour needs the bench's scoreboard against a flat model: random traffic, writes blocked by a low chip select, address-boundary and shared-row or shared-column cases. Only that comparison shows that row and column routing keep every word apart and that only the addressed bit in each bank changes.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic acc_e decode_acc(input logic cs, input logic we);
    if (!cs)     return ACC_IDLE;
    else if (we) return ACC_WRITE;
    else         return ACC_READ;
  endfunction

endpackage

// File: rtl/sram_row_dec.sv
module sram_row_dec #(
  parameter int ROW_W = 4,
  localparam int ROWS = 1 << ROW_W
) (
  input  logic             en_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [ROWS-1:0]  sel_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign sel_o[r] = en_i && (row_i == ROW_W'(r));
  end
endmodule

// File: rtl/sram_subarray.sv
module sram_subarray #(
  parameter int ROW_W = 4,
  parameter int COL_W = 3,
  localparam int ROWS = 1 << ROW_W,
  localparam int COLS = 1 << COL_W
) (
  input  logic             clk_i,
  input  logic [ROWS-1:0]  row_sel_i,
  input  logic             wr_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             bit_i,
  output logic [COLS-1:0]  row_o
);
  logic [COLS-1:0] cells_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i) begin
      if (wr_i && row_sel_i[r]) cells_q[r][col_i] <= bit_i;
    end
  end

  // one-hot and-or row read
  always_comb begin
    row_o = '0;
    for (int r = 0; r < ROWS; r++) begin
      row_o = row_o | (cells_q[r] & {COLS{row_sel_i[r]}});
    end
  end
endmodule

// File: rtl/sram_col_mux.sv
module sram_col_mux #(
  parameter int COL_W = 3,
  localparam int COLS = 1 << COL_W
) (
  input  logic [COLS-1:0]  row_i,
  input  logic [COL_W-1:0] col_i,
  output logic             bit_o
);
  assign bit_o = row_i[col_i];
endmodule

// File: rtl/sram_bank.sv
module sram_bank
  import sram_bank_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter int              ROW_W    = 4,
  parameter int              COL_W    = 3,
  parameter bit              IDLE_Z   = 1'b0,
  parameter logic [DATA_W-1:0] IDLE_VAL = '1,
  localparam int             ADDR_W   = ROW_W + COL_W,
  localparam int             ROWS     = 1 << ROW_W,
  localparam int             COLS     = 1 << COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  acc_e              acc;
  logic [ROW_W-1:0]  row_idx;
  logic [COL_W-1:0]  col_idx;
  logic [ROWS-1:0]   row_sel;
  logic [DATA_W-1:0] rd_bits;
  logic [DATA_W-1:0] rdata_q;

  assign acc     = decode_acc(cs_i, we_i);
  assign row_idx = addr_i[ADDR_W-1:COL_W];
  assign col_idx = addr_i[COL_W-1:0];

  sram_row_dec #(.ROW_W(ROW_W)) u_row_dec (
    .en_i  (acc != ACC_IDLE),
    .row_i (row_idx),
    .sel_o (row_sel)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_bank
    logic [COLS-1:0] row_bits;

    sram_subarray #(.ROW_W(ROW_W), .COL_W(COL_W)) u_sub (
      .clk_i     (clk_i),
      .row_sel_i (row_sel),
      .wr_i      (acc == ACC_WRITE),
      .col_i     (col_idx),
      .bit_i     (wdata_i[b]),
      .row_o     (row_bits)
    );

    sram_col_mux #(.COL_W(COL_W)) u_col (
      .row_i (row_bits),
      .col_i (col_idx),
      .bit_o (rd_bits[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_q <= '0;
    else if (acc == ACC_READ)  rdata_q <= rd_bits;
  end

  if (IDLE_Z) begin : g_out_z
    assign rdata_o = oe_i ? rdata_q : {DATA_W{1'bz}};
  end else begin : g_out_idle
    assign rdata_o = oe_i ? rdata_q : IDLE_VAL;
  end
endmodule

// File: rtl/sram_bank_chk.sv
module sram_bank_chk #(
  parameter int              DATA_W   = 8,
  parameter int              ADDR_W   = 7,
  parameter bit              IDLE_Z   = 1'b0,
  parameter logic [DATA_W-1:0] IDLE_VAL = '1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              we_i,
  input logic              oe_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] rd_q
);
  // R5
  desel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> $stable(rd_q));

  // R6
  write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && we_i) |=> $stable(rd_q));

  // R3
  raw_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cs_i && we_i) && cs_i && !we_i && addr_i == $past(addr_i))
    |=> rd_q == $past(wdata_i, 2));

  // R7
  oe_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> rdata_o == rd_q);

  if (!IDLE_Z) begin : g_idle
    // R7
    oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_i |-> rdata_o == IDLE_VAL);
  end

  // R8
  always @(posedge clk_i) begin
    if (!rst_ni) reset_clear_chk: assert (rd_q == '0);
  end
endmodule

bind sram_bank sram_bank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDLE_Z(IDLE_Z), .IDLE_VAL(IDLE_VAL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .oe_i(oe_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rd_q(rdata_q)
);

// File: tb/tb_sram_bank.sv
module tb_sram_bank;
  localparam int DATA_W = 8;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 3;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int WORDS  = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] IDLE = '1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_i = 1'b0, we_i = 1'b0, oe_i = 1'b1;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] wdata_i = '0;
  logic [DATA_W-1:0] rdata_o;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] ref_mem [WORDS];
  logic [DATA_W-1:0] exp_q [$];
  string tag_q [$];

  always #5 clk_i = ~clk_i;

  sram_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .oe_i(oe_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  task automatic chk(input logic ok, input string req,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: one access per cycle, reads push expectations
  task automatic op(input logic cs, input logic we, input logic [ADDR_W-1:0] a,
                    input logic [DATA_W-1:0] d, input string tag);
    @(negedge clk_i);
    cs_i = cs; we_i = we; oe_i = 1'b1; addr_i = a; wdata_i = d;
    if (cs && we) ref_mem[a] = d;
    if (cs && !we) begin
      exp_q.push_back(ref_mem[a]);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle_cyc();
    @(negedge clk_i);
    cs_i = 1'b0; we_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      logic fire;
      @(posedge clk_i);
      fire = rst_ni && cs_i && !we_i;
      #2;
      if (fire) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected read", rdata_o, '0);
        else begin
          logic [DATA_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rdata_o == e, t, rdata_o, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    chk(1'b0, "watchdog", '0, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] v;
    void'($urandom(11));
    // R8 reset state
    repeat (3) @(negedge clk_i);
    chk(rdata_o == '0, "R8 reset clear", rdata_o, '0);
    oe_i = 1'b0; #1;
    chk(rdata_o == IDLE, "R7 idle during reset", rdata_o, IDLE);
    oe_i = 1'b1;
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 fill
    for (int a = 0; a < WORDS; a++) op(1, 1, ADDR_W'(a), DATA_W'($urandom), "R2");
    // R1 R3 read all
    for (int a = 0; a < WORDS; a++) op(1, 0, ADDR_W'(a), '0, "R1 R3 sweep");

    // R1 boundaries, shared row and shared column
    op(1, 1, '0, 8'h5A, "R1");
    op(1, 1, '1, 8'hC3, "R1");
    op(1, 1, {4'd3, 3'd2}, 8'h11, "R1");
    op(1, 1, {4'd3, 3'd5}, 8'h22, "R1");
    op(1, 1, {4'd9, 3'd2}, 8'h44, "R1");
    op(1, 0, '0, '0, "R1 addr zero");
    op(1, 0, '1, '0, "R1 addr max");
    op(1, 0, {4'd3, 3'd2}, '0, "R1 shared row a");
    op(1, 0, {4'd3, 3'd5}, '0, "R1 shared row b");
    op(1, 0, {4'd9, 3'd2}, '0, "R1 shared col");

    // R3 read right after write
    op(1, 1, 7'd40, 8'hA7, "R3");
    op(1, 0, 7'd40, '0, "R3 read after write");

    // R4 deselected write ignored
    op(0, 1, 7'd40, 8'h00, "R4");
    op(1, 0, 7'd40, '0, "R4 blocked write");
    op(0, 1, '1, 8'h3C, "R4");
    op(1, 0, '1, '0, "R4 blocked write max");

    // R5 R6 R7 hold and output gating
    op(1, 0, 7'd40, '0, "R3");
    v = ref_mem[7'd40];
    @(negedge clk_i); cs_i = 1'b0; we_i = 1'b1; addr_i = 7'd1; wdata_i = 8'hFF;
    #1 chk(rdata_o == v, "R3 value before hold", rdata_o, v);
    @(negedge clk_i);
    chk(rdata_o == v, "R5 deselect hold", rdata_o, v);
    cs_i = 1'b1; we_i = 1'b1; addr_i = 7'd77; wdata_i = 8'h0F; ref_mem[7'd77] = 8'h0F;
    @(negedge clk_i);
    chk(rdata_o == v, "R6 write hold", rdata_o, v);
    cs_i = 1'b0; we_i = 1'b0; oe_i = 1'b0; #1;
    chk(rdata_o == IDLE, "R7 oe low idle", rdata_o, IDLE);
    oe_i = 1'b1; #1;
    chk(rdata_o == v, "R7 oe high passes", rdata_o, v);
    op(1, 0, 7'd77, '0, "R2 R6 written during hold");

    // random mixed traffic
    for (int i = 0; i < 600; i++) begin
      int k;
      k = int'($urandom % 4);
      if (k == 0)      op(1, 1, ADDR_W'($urandom), DATA_W'($urandom), "R2");
      else if (k == 1) op(0, 1, ADDR_W'($urandom), DATA_W'($urandom), "R4");
      else             op(1, 0, ADDR_W'($urandom), '0, "R2 R3 random read");
    end
    // final sweep
    for (int a = 0; a < WORDS; a++) op(1, 0, ADDR_W'(a), '0, "R2 R4 final sweep");
    idle_cyc();
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R3 pending reads", DATA_W'(exp_q.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule